// File: doc/BRIEF.md
# Current-Sense Startup and Reset-Watchdog Sequencer

This block is the digital supervisor in front of an integrating current-sense front end. It receives two supply comparator flags and a calibration-finished strobe from the analog side. It also receives the already-decoded integrator reset request. From these it decides when the sensed output may be shown, when reset requests are allowed through, and when a measurement has run too long without a reset.

After power is good, the sequencer pulses a calibration start. It keeps the reset request path closed until calibration reports done. It then waits for the first request. Each request opens an integrator reset phase, and a measurement phase follows when the request falls. A watchdog counter starts each time a reset phase is entered. If the count reaches its limit before a fresh rising request edge, the block forces the output to minimum and pulls the active-low fault flag. Losing supply returns everything to lockout from any state.

All inputs are assumed synchronous to `clk`. The supply flags come from two comparators. `sup_above_rise` compares against the higher, exit threshold. `sup_above_fall` compares against the lower, drop threshold.

Top module: `sense_startup_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, the block is in lockout: `out_force_min`=1, `rst_inputs_en`=0, `integ_reset`=0, `cal_start`=0, `fault_n`=1. While in lockout, `rst_req` has no effect on any output.
- R2: Power is accepted only when `sup_above_rise`=1 and `sup_above_fall`=1 at the same edge. If `sup_above_fall`=1 while `sup_above_rise`=0, the present supply condition is kept. `sup_above_fall`=0 always counts as a supply drop, even when `sup_above_rise`=1.
- R3: Two edges after power is accepted, `cal_start` is high for exactly one cycle. For the whole calibration, `out_force_min`=1 and `rst_inputs_en`=0, and `rst_req` is ignored.
- R4: A `cal_done` pulse sampled during calibration makes `rst_inputs_en`=1 from the next cycle on. The output stays forced to minimum until a request arrives. The first cycle with `rst_req`=1 after that starts a reset phase at the next edge.
- R5: During a reset phase, `integ_reset`=1 and `out_force_min`=1. The edge that samples `rst_req`=0 starts measurement, with `out_force_min`=0 and `integ_reset`=0.
- R6: The watchdog runs for WD_CYCLES clock cycles from the first cycle of a reset phase. If no rising edge of `rst_req` is sampled in that time, the block enters fault: `fault_n`=0, `out_force_min`=1. A rising edge sampled during measurement restarts the count with a new reset phase.
- R7: A rising edge of `rst_req` sampled in fault starts a reset phase at the next edge, with `fault_n`=1 and `integ_reset`=1.
- R8: A supply drop in any state, including fault, brings the block to lockout two edges later, with `fault_n`=1 and `rst_inputs_en`=0. A new calibration, with a new `cal_start` pulse, is then needed.
- R9: A request held high does not clear a fault, and neither does its falling edge. A reset held high for WD_CYCLES also produces a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_above_rise | input | 1 | Supply above the upper (exit) threshold |
| sup_above_fall | input | 1 | Supply above the lower (drop) threshold |
| cal_done | input | 1 | Calibration finished strobe |
| rst_req | input | 1 | Decoded integrator reset request, level |
| out_force_min | output | 1 | Hold sensed output at its minimum |
| rst_inputs_en | output | 1 | Reset request path enabled |
| cal_start | output | 1 | One-cycle calibration start pulse |
| fault_n | output | 1 | Active-low watchdog fault |
| integ_reset | output | 1 | Integrator held in reset |

## Verification
The hardest condition to reach is a fault caused by a reset request that never falls, rather than by one that never comes. In that case the only event that may clear the fault is a fresh rising edge after the request has been low. The stimulus holds `rst_req` high through the whole watchdog window and keeps it high after the fault. It then drops the request and raises it again, and checks that only the rise clears the fault. A second scenario forces a fault and then drops the supply, to show that lockout clears the fault and requires a new calibration. A behavioural model in the bench checks all outputs on every cycle. A stretch of random requests, calibration strobes and occasional supply drops then exercises the state transitions in mixed orders.

// File: rtl/ssq_pkg.sv
// Shared types of the startup sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ssq_pkg;

    // Sequencer phases, from power-up through measurement and fault.
    typedef enum logic [2:0] {
        ST_LOCK = 3'd0,
        ST_CAL  = 3'd1,
        ST_ARM  = 3'd2,
        ST_RST  = 3'd3,
        ST_MEAS = 3'd4,
        ST_FLT  = 3'd5
    } ssq_state_e;

endpackage

// File: rtl/ssq_supply_gate.sv
// Turns the two supply comparator flags into one registered power-good bit.
// Hysteresis: the flag sets only on the upper comparator and clears on the lower one.
// Assumes both flags are already synchronous to clk.
module ssq_supply_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic above_rise,
    input  logic above_fall,
    output logic pwr_ok
);

    // Set on upper threshold, clear on lower threshold; a drop has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwr_ok <= 1'b0;
        else if (!above_fall)
            pwr_ok <= 1'b0;
        else if (above_rise)
            pwr_ok <= 1'b1;
    end

endmodule

// File: rtl/ssq_req_edge.sv
// Rising-edge detector for the decoded reset request.
// Assumes req is synchronous to clk; rise is combinational from the current level.
module ssq_req_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic rise
);

    logic req_q;

    // Remember the level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else
            req_q <= req;
    end

    // The request is high now and was low one cycle before.
    always_comb rise = req && !req_q;

endmodule

// File: rtl/ssq_wd_timer.sv
// Watchdog counter for the reset-to-reset interval.
// It is cleared when a reset phase is entered and counts while run is high.
// expire goes high in the last allowed cycle. Assumes LIMIT >= 2.
module ssq_wd_timer #(
    parameter int LIMIT = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expire
);

    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Restart on clear or idle; count up to LAST and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || !run)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    // The final counted cycle of the window.
    always_comb expire = run && (cnt == LAST);

endmodule

// File: rtl/ssq_fsm.sv
// Phase controller: lockout, calibration, armed, reset, measure and fault.
// A supply loss overrides every other event. A rising request beats watchdog expiry in measurement.
// Assumes rise comes from the same req level that is presented here.
module ssq_fsm
    import ssq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic       cal_done,
    input  logic       req,
    input  logic       rise,
    input  logic       wd_expire,
    output ssq_state_e state,
    output logic       wd_clr,
    output logic       wd_run,
    output logic       cal_pulse
);

    ssq_state_e nxt;

    // Next-phase selection and watchdog restart request.
    always_comb begin
        nxt    = state;
        wd_clr = 1'b0;
        if (!pwr_ok) begin
            nxt = ST_LOCK;
        end else begin
            unique case (state)
                ST_LOCK: nxt = ST_CAL;
                ST_CAL:  if (cal_done) nxt = ST_ARM;
                ST_ARM:  if (req) begin
                             nxt    = ST_RST;
                             wd_clr = 1'b1;
                         end
                ST_RST:  if (wd_expire) nxt = ST_FLT;
                         else if (!req) nxt = ST_MEAS;
                ST_MEAS: if (rise) begin
                             nxt    = ST_RST;
                             wd_clr = 1'b1;
                         end else if (wd_expire) begin
                             nxt = ST_FLT;
                         end
                ST_FLT:  if (rise) begin
                             nxt    = ST_RST;
                             wd_clr = 1'b1;
                         end
                default: nxt = ST_LOCK;
            endcase
        end
    end

    // The watchdog window covers both the reset and the measurement phase.
    always_comb wd_run = (state == ST_RST) || (state == ST_MEAS);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_LOCK;
        else
            state <= nxt;
    end

    // One-cycle calibration start, issued as lockout is left.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cal_pulse <= 1'b0;
        else
            cal_pulse <= (state == ST_LOCK) && pwr_ok;
    end

endmodule

// File: rtl/sense_startup_ctrl.sv
// Top of the startup sequencer with measurement watchdog.
// It ties together the supply gate, the request edge detector, the watchdog and the phase FSM.
// All outputs are decoded from registered state, so they change one cycle after the deciding edge.
module sense_startup_ctrl #(
    parameter int WD_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_rise,
    input  logic sup_above_fall,
    input  logic cal_done,
    input  logic rst_req,
    output logic out_force_min,
    output logic rst_inputs_en,
    output logic cal_start,
    output logic fault_n,
    output logic integ_reset
);
    import ssq_pkg::*;

    logic       pwr_ok;
    logic       req_rise;
    logic       wd_expire;
    logic       wd_clr;
    logic       wd_run;
    ssq_state_e state;

    ssq_supply_gate u_supply (
        .clk        (clk),
        .rst_n      (rst_n),
        .above_rise (sup_above_rise),
        .above_fall (sup_above_fall),
        .pwr_ok     (pwr_ok)
    );

    ssq_req_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rst_req),
        .rise  (req_rise)
    );

    ssq_wd_timer #(.LIMIT(WD_CYCLES)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wd_clr),
        .run    (wd_run),
        .expire (wd_expire)
    );

    ssq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .cal_done  (cal_done),
        .req       (rst_req),
        .rise      (req_rise),
        .wd_expire (wd_expire),
        .state     (state),
        .wd_clr    (wd_clr),
        .wd_run    (wd_run),
        .cal_pulse (cal_start)
    );

    // Output decode from the phase register.
    always_comb begin
        out_force_min = (state != ST_MEAS);
        rst_inputs_en = (state == ST_ARM) || (state == ST_RST) ||
                        (state == ST_MEAS) || (state == ST_FLT);
        fault_n       = (state != ST_FLT);
        integ_reset   = (state == ST_RST);
    end

endmodule

// File: rtl/sense_startup_ctrl_chk.sv
// Assertion checker for sense_startup_ctrl, attached by bind. It observes ports only.
module sense_startup_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sup_above_fall,
    input logic cal_done,
    input logic rst_req,
    input logic out_force_min,
    input logic rst_inputs_en,
    input logic cal_start,
    input logic fault_n,
    input logic integ_reset
);

    // R3: the calibration start never lasts two cycles.
    a_r3_cal_single: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    // R3, R1: with the request path closed, the output is held at minimum.
    a_r3_closed_forces_min: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_inputs_en |-> out_force_min);

    // R4: the request path opens only after a calibration-done strobe.
    a_r4_open_after_cal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_inputs_en) |-> $past(cal_done));

    // R5: an integrator reset keeps the output at minimum.
    a_r5_reset_forces_min: assert property (@(posedge clk) disable iff (!rst_n)
        integ_reset |-> out_force_min);

    // R6: a fault holds the output at minimum with the path still open.
    a_r6_fault_forces_min: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (out_force_min && rst_inputs_en));

    // R7: a rising request seen in fault starts a reset phase and clears the flag.
    a_r7_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && rst_req && !$past(rst_req)) |=> (fault_n && integ_reset));

    // R8: a supply drop reaches lockout two edges later.
    a_r8_drop_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_above_fall |=> ##1 (!rst_inputs_en && fault_n));

endmodule

bind sense_startup_ctrl sense_startup_ctrl_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .sup_above_fall (sup_above_fall),
    .cal_done       (cal_done),
    .rst_req        (rst_req),
    .out_force_min  (out_force_min),
    .rst_inputs_en  (rst_inputs_en),
    .cal_start      (cal_start),
    .fault_n        (fault_n),
    .integ_reset    (integ_reset)
);

// File: tb/sense_startup_ctrl_tb_top.sv
`timescale 1ns/1ps
module sense_startup_ctrl_tb_top;

    localparam int WD = 40;
    localparam time TCLK = 20ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_rise = 1'b0;
    logic sup_fall = 1'b0;
    logic cal_done = 1'b0;
    logic rst_req = 1'b0;
    logic out_force_min, rst_inputs_en, cal_start, fault_n, integ_reset;

    int n_tests = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;

    always #(TCLK/2) clk = ~clk;

    sense_startup_ctrl #(.WD_CYCLES(WD)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sup_above_rise (sup_rise),
        .sup_above_fall (sup_fall),
        .cal_done       (cal_done),
        .rst_req        (rst_req),
        .out_force_min  (out_force_min),
        .rst_inputs_en  (rst_inputs_en),
        .cal_start      (cal_start),
        .fault_n        (fault_n),
        .integ_reset    (integ_reset)
    );

    // Reference model: 0 lockout, 1 calibrate, 2 armed, 3 reset, 4 measure, 5 fault.
    int m_st = 0;
    int m_cnt = 0;
    bit m_pwr = 1'b0;
    bit m_req_q = 1'b0;
    bit m_cal = 1'b0;

    always @(posedge clk) begin : model
        bit rise;
        int nst;
        int ncnt;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pwr = 1'b0; m_req_q = 1'b0; m_cal = 1'b0;
        end else begin
            rise = rst_req && !m_req_q;
            nst  = m_st;
            ncnt = 0;
            if (!m_pwr) nst = 0;
            else begin
                case (m_st)
                    0: nst = 1;
                    1: if (cal_done) nst = 2;
                    2: if (rst_req) nst = 3;
                    3: begin
                        if (m_cnt == WD-1) nst = 5;
                        else if (!rst_req) nst = 4;
                        ncnt = m_cnt + 1;
                    end
                    4: begin
                        if (rise) nst = 3;
                        else if (m_cnt == WD-1) nst = 5;
                        ncnt = rise ? 0 : m_cnt + 1;
                    end
                    default: if (rise) nst = 3;
                endcase
            end
            m_cal   = (m_st == 0) && m_pwr;
            m_pwr   = !sup_fall ? 1'b0 : (sup_rise ? 1'b1 : m_pwr);
            m_req_q = rst_req;
            m_st    = nst;
            m_cnt   = ncnt;
        end
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string tag_of(int st);
        case (st)
            0: return "R1";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            chk(tag_of(m_st), "out_force_min", out_force_min, m_st != 4);
            chk(tag_of(m_st), "rst_inputs_en", rst_inputs_en, m_st >= 2);
            chk(tag_of(m_st), "fault_n",       fault_n,       m_st != 5);
            chk(tag_of(m_st), "integ_reset",   integ_reset,   m_st == 3);
            chk("R3", "cal_start", cal_start, m_cal);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        #(TCLK * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin : stim
        step(3);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R1: reset state
        chk("R1", "out_force_min", out_force_min, 1'b1);
        chk("R1", "rst_inputs_en", rst_inputs_en, 1'b0);
        chk("R1", "fault_n", fault_n, 1'b1);
        chk("R1", "cal_start", cal_start, 1'b0);

        // R1: requests toggled in lockout do nothing
        for (int i = 0; i < 6; i++) begin
            rst_req = ~rst_req;
            step(1);
            chk("R1", "integ_reset", integ_reset, 1'b0);
        end
        rst_req = 1'b0;

        // R2: lower comparator alone keeps lockout
        sup_fall = 1'b1;
        step(5);
        chk("R2", "rst_inputs_en", rst_inputs_en, 1'b0);
        chk("R2", "cal_start", cal_start, 1'b0);

        // R3: accept power, expect one calibration start pulse
        sup_rise = 1'b1;
        step(1);
        sup_rise = 1'b0;
        step(1);
        chk("R3", "cal_start", cal_start, 1'b1);
        step(1);
        chk("R3", "cal_start", cal_start, 1'b0);
        for (int i = 0; i < 5; i++) begin
            rst_req = ~rst_req;
            step(1);
            chk("R3", "rst_inputs_en", rst_inputs_en, 1'b0);
        end
        rst_req = 1'b0;
        step(1);

        // R4: calibration done opens the path
        cal_done = 1'b1;
        step(1);
        cal_done = 1'b0;
        chk("R4", "rst_inputs_en", rst_inputs_en, 1'b1);
        chk("R4", "out_force_min", out_force_min, 1'b1);
        step(3);
        chk("R4", "integ_reset", integ_reset, 1'b0);

        // R5, R6: periodic resets inside the watchdog window
        for (int i = 0; i < 4; i++) begin
            rst_req = 1'b1;
            step(3);
            chk("R5", "integ_reset", integ_reset, 1'b1);
            rst_req = 1'b0;
            step(1);
            chk("R5", "out_force_min", out_force_min, 1'b0);
            step(20);
            chk("R6", "fault_n", fault_n, 1'b1);
        end

        // R6: requests stop, fault follows
        step(WD + 5);
        chk("R6", "fault_n", fault_n, 1'b0);
        chk("R6", "out_force_min", out_force_min, 1'b1);

        // R7: rising request clears fault
        rst_req = 1'b1;
        step(1);
        chk("R7", "fault_n", fault_n, 1'b1);
        chk("R7", "integ_reset", integ_reset, 1'b1);
        rst_req = 1'b0;
        step(2);

        // R9: stuck-high reset faults, and a held or falling request does not clear it
        rst_req = 1'b1;
        step(WD + 5);
        chk("R9", "fault_n", fault_n, 1'b0);
        step(10);
        chk("R9", "fault_n", fault_n, 1'b0);
        rst_req = 1'b0;
        step(2);
        chk("R9", "fault_n", fault_n, 1'b0);
        rst_req = 1'b1;
        step(1);
        chk("R7", "fault_n", fault_n, 1'b1);
        rst_req = 1'b0;
        step(5);

        // R8: fault, then supply drop clears it and forces lockout
        step(WD + 5);
        chk("R8", "fault_n before drop", fault_n, 1'b0);
        sup_fall = 1'b0;
        step(2);
        chk("R8", "fault_n", fault_n, 1'b1);
        chk("R8", "rst_inputs_en", rst_inputs_en, 1'b0);
        chk("R8", "out_force_min", out_force_min, 1'b1);
        // R2: upper flag with lower flag low is still a drop
        sup_rise = 1'b1;
        step(3);
        chk("R2", "rst_inputs_en", rst_inputs_en, 1'b0);
        sup_rise = 1'b0;
        sup_fall = 1'b1;
        step(3);
        chk("R8", "rst_inputs_en", rst_inputs_en, 1'b0);
        sup_rise = 1'b1;
        step(1);
        sup_rise = 1'b0;
        step(1);
        chk("R8", "cal_start", cal_start, 1'b1);
        cal_done = 1'b1;
        step(1);
        cal_done = 1'b0;
        chk("R8", "rst_inputs_en", rst_inputs_en, 1'b1);

        // Mixed random traffic, checked cycle by cycle against the model
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 9) == 0) rst_req = ~rst_req;
            cal_done = (($urandom % 8) == 0);
            sup_rise = (($urandom % 4) == 0);
            sup_fall = (($urandom % 150) != 0);
            step(1);
        end

        step(2);
        finish_run();
    end

endmodule